// File: doc/BRIEF.md
# Bidirectional Pad Boundary-Scan Cell Pair

This block sits beside one bidirectional pad and places it under control of a test access port. It holds a direction-control cell and a data cell, plus an optional input cell, linked into one serial segment. Each cell has two flip-flops: a capture/shift stage clocked on the rising test-clock edge and an update stage clocked on the falling edge. Normally the core drives the pad value and enable, and the pad input flows straight back into the core. When test mode is raised, the update stages take over. The direction cell's update output sets the pad enable, and the data cell's update output sets the pad value. If the input cell is present, its update output replaces the pad input seen by the core.

A test access port controller supplies four signals: a capture/shift enable that is active in the capture and shift data-register states, a shift-versus-capture select, an update enable that is active in the data-register update state, and the test-mode select. Pad segments are chained scan-out to scan-in to form a full boundary register.

Top module: `bsc_bidir_pad`

## Requirements
- R1: A synchronous active-high reset clears every capture/shift stage and every update stage to 0. Right after reset, with `test_mode` high, the pad is therefore undriven (`pad_oe`=0, `pad_out`=0).
- R2: When `dr_en`=1 and `shift_sel`=1, each capture/shift stage loads its predecessor on the rising `tck` edge. The serial order is: `scan_in`, then the direction cell, then the data cell, then the input cell (when present), then `scan_out`. A bit therefore reaches `scan_out` after as many rising edges as there are cells.
- R3: When `dr_en`=1 and `shift_sel`=0, the direction cell captures `core_oe`.
- R4: On the same capture, the data cell captures `core_out` if the effective `pad_oe` is 1, and `pad_in` if it is 0.
- R5: On the same capture, the input cell, when present, captures `pad_in`.
- R6: When `update_en`=1, each update stage loads its capture/shift stage on the falling `tck` edge.
- R7: While `update_en`=0, the update stages hold their values, so pad outputs do not change while data shifts through.
- R8: With `test_mode`=0: `pad_out`=`core_out`, `pad_oe`=`core_oe` and `core_in`=`pad_in`.
- R9: With `test_mode`=1: `pad_oe` equals the direction cell's update stage, and `pad_out` equals the data cell's update stage.
- R10: With `test_mode`=1 and the input cell present, `core_in` equals the input cell's update stage. Without the input cell, `core_in` is always `pad_in`.
- R11: While `dr_en`=0, the capture/shift stages hold their values whatever `shift_sel` and `scan_in` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; rising edge shifts and captures, falling edge updates |
| rst | input | 1 | Synchronous active-high reset |
| scan_in | input | 1 | Serial data into the direction cell |
| shift_sel | input | 1 | 1 = shift, 0 = parallel capture |
| dr_en | input | 1 | Enables the capture/shift stages |
| update_en | input | 1 | Enables the update stages |
| test_mode | input | 1 | 1 = update stages own the pad and the core input |
| core_out | input | 1 | Pad value from the core |
| core_oe | input | 1 | Pad output enable from the core (1 = drive) |
| pad_in | input | 1 | Value received from the pad buffer |
| scan_out | output | 1 | Serial data from the last cell |
| pad_out | output | 1 | Value to the pad buffer |
| pad_oe | output | 1 | Output enable to the pad buffer |
| core_in | output | 1 | Pad input value presented to the core |

## Verification
The bench builds two segments and chains them: the first with the input cell and the second without it, giving a five-cell serial path. This exercises both settings of the input-cell parameter in one run. It also shows that a segment's scan-out feeds the next segment's direction cell in the right order. It covers data-cell captures whose source switches with a test-mode pad direction, as well as with the core's own direction.

// File: rtl/bsc_pkg.sv
`timescale 1ns/1ps
package bsc_pkg;

    localparam int DIR_IDX  = 0;
    localparam int DATA_IDX = 1;
    localparam int IN_IDX   = 2;

    typedef enum logic [1:0] {
        CELL_DIR  = 2'd0,
        CELL_DATA = 2'd1,
        CELL_IN   = 2'd2
    } cell_role_e;

    typedef struct packed {
        logic val;
        logic oe;
    } pad_drv_t;

    function automatic cell_role_e role_of(input int idx);
        if (idx == DIR_IDX)       return CELL_DIR;
        else if (idx == DATA_IDX) return CELL_DATA;
        else                      return CELL_IN;
    endfunction

    function automatic logic capture_src(input cell_role_e role,
                                         input pad_drv_t   core,
                                         input pad_drv_t   pad,
                                         input logic       pad_in);
        logic v;
        case (role)
            CELL_DIR:  v = core.oe;
            CELL_DATA: v = pad.oe ? core.val : pad_in;
            default:   v = pad_in;
        endcase
        return v;
    endfunction

    function automatic pad_drv_t pick_drive(input logic     tm,
                                            input pad_drv_t core,
                                            input pad_drv_t scan);
        return tm ? scan : core;
    endfunction

endpackage

// File: rtl/bsc_stage.sv
`timescale 1ns/1ps
module bsc_stage (
    input  logic tck,
    input  logic rst,
    input  logic dr_en,
    input  logic shift_sel,
    input  logic sin,
    input  logic par_in,
    input  logic update_en,
    output logic q_cap,
    output logic q_upd
);

    always_ff @(posedge tck) begin
        if (rst)        q_cap <= 1'b0;
        else if (dr_en) q_cap <= shift_sel ? sin : par_in;
    end

    always_ff @(negedge tck) begin
        if (rst)            q_upd <= 1'b0;
        else if (update_en) q_upd <= q_cap;
    end

endmodule

// File: rtl/bsc_pad_mux.sv
`timescale 1ns/1ps
module bsc_pad_mux
    import bsc_pkg::*;
#(
    parameter bit HAS_IN_CELL = 1'b1
) (
    input  logic     test_mode,
    input  pad_drv_t core_drv,
    input  pad_drv_t scan_drv,
    input  logic     pad_in,
    input  logic     in_upd,
    output pad_drv_t pad_drv,
    output logic     core_in
);

    assign pad_drv = pick_drive(test_mode, core_drv, scan_drv);

    generate
        if (HAS_IN_CELL) begin : g_in_cell
            assign core_in = test_mode ? in_upd : pad_in;
        end else begin : g_no_in_cell
            logic unused_in;
            assign unused_in = in_upd;
            assign core_in   = pad_in;
        end
    endgenerate

endmodule

// File: rtl/bsc_bidir_pad.sv
`timescale 1ns/1ps
module bsc_bidir_pad
    import bsc_pkg::*;
#(
    parameter bit HAS_IN_CELL = 1'b1
) (
    input  logic tck,
    input  logic rst,
    input  logic scan_in,
    input  logic shift_sel,
    input  logic dr_en,
    input  logic update_en,
    input  logic test_mode,
    input  logic core_out,
    input  logic core_oe,
    input  logic pad_in,
    output logic scan_out,
    output logic pad_out,
    output logic pad_oe,
    output logic core_in
);

    localparam int NCELL = HAS_IN_CELL ? 3 : 2;

    logic [NCELL-1:0] cap_q;
    logic [NCELL-1:0] upd_q;
    pad_drv_t         core_drv, scan_drv, eff_drv;

    assign core_drv = '{val: core_out, oe: core_oe};
    assign scan_drv = '{val: upd_q[DATA_IDX], oe: upd_q[DIR_IDX]};

    generate
        for (genvar i = 0; i < NCELL; i++) begin : g_cell
            logic sin;
            logic par;
            if (i == 0) begin : g_head
                assign sin = scan_in;
            end else begin : g_link
                assign sin = cap_q[i-1];
            end
            assign par = capture_src(role_of(i), core_drv, eff_drv, pad_in);
            bsc_stage u_stage (
                .tck       (tck),
                .rst       (rst),
                .dr_en     (dr_en),
                .shift_sel (shift_sel),
                .sin       (sin),
                .par_in    (par),
                .update_en (update_en),
                .q_cap     (cap_q[i]),
                .q_upd     (upd_q[i])
            );
        end
    endgenerate

    bsc_pad_mux #(.HAS_IN_CELL(HAS_IN_CELL)) u_mux (
        .test_mode (test_mode),
        .core_drv  (core_drv),
        .scan_drv  (scan_drv),
        .pad_in    (pad_in),
        .in_upd    (upd_q[NCELL-1]),
        .pad_drv   (eff_drv),
        .core_in   (core_in)
    );

    assign pad_out  = eff_drv.val;
    assign pad_oe   = eff_drv.oe;
    assign scan_out = cap_q[NCELL-1];

endmodule

// File: rtl/bsc_bidir_pad_chk.sv
`timescale 1ns/1ps
module bsc_bidir_pad_chk #(
    parameter bit HAS_IN_CELL = 1'b1
) (
    input logic                         tck,
    input logic                         rst,
    input logic                         scan_in,
    input logic                         shift_sel,
    input logic                         dr_en,
    input logic                         update_en,
    input logic                         test_mode,
    input logic                         core_out,
    input logic                         core_oe,
    input logic                         pad_in,
    input logic                         pad_out,
    input logic                         pad_oe,
    input logic                         core_in,
    input logic [(HAS_IN_CELL?3:2)-1:0] cap_q,
    input logic [(HAS_IN_CELL?3:2)-1:0] upd_q
);

    localparam int NC = HAS_IN_CELL ? 3 : 2;

    AST_RESET_CLEAR: assert property (@(posedge tck)
        $fell(rst) |-> (cap_q == '0 && upd_q == '0)); // R1

    AST_SHIFT_ENTRY: assert property (@(posedge tck) disable iff (rst)
        (dr_en && shift_sel) |=> (cap_q[0] == $past(scan_in))); // R2

    AST_SHIFT_LINK: assert property (@(posedge tck) disable iff (rst)
        (dr_en && shift_sel) |=> (cap_q[1] == $past(cap_q[0]))); // R2

    AST_CAP_DIR: assert property (@(posedge tck) disable iff (rst)
        (dr_en && !shift_sel) |=> (cap_q[0] == $past(core_oe))); // R3

    AST_CAP_DATA_DRIVE: assert property (@(posedge tck) disable iff (rst)
        (dr_en && !shift_sel && pad_oe) |=> (cap_q[1] == $past(core_out))); // R4

    AST_CAP_DATA_RECV: assert property (@(posedge tck) disable iff (rst)
        (dr_en && !shift_sel && !pad_oe) |=> (cap_q[1] == $past(pad_in))); // R4

    AST_UPD_LOAD: assert property (@(posedge tck) disable iff (rst)
        update_en |-> (upd_q == cap_q)); // R6

    AST_UPD_HOLD: assert property (@(posedge tck) disable iff (rst)
        !update_en |-> $stable(upd_q)); // R7

    AST_NORMAL_PASS: assert property (@(posedge tck) disable iff (rst)
        !test_mode |-> (pad_out == core_out && pad_oe == core_oe)); // R8

    AST_TEST_DRIVE: assert property (@(posedge tck) disable iff (rst)
        test_mode |-> (pad_oe == upd_q[0] && pad_out == upd_q[1])); // R9

    AST_CAP_HOLD: assert property (@(posedge tck) disable iff (rst)
        !dr_en |=> $stable(cap_q)); // R11

    generate
        if (HAS_IN_CELL) begin : g_in
            AST_CAP_INCELL: assert property (@(posedge tck) disable iff (rst)
                (dr_en && !shift_sel) |=> (cap_q[NC-1] == $past(pad_in))); // R5
            AST_CORE_IN_SCAN: assert property (@(posedge tck) disable iff (rst)
                test_mode |-> (core_in == upd_q[NC-1])); // R10
        end else begin : g_no_in
            AST_CORE_IN_PASS: assert property (@(posedge tck) disable iff (rst)
                1'b1 |-> (core_in == pad_in)); // R10
        end
    endgenerate

endmodule

bind bsc_bidir_pad bsc_bidir_pad_chk #(.HAS_IN_CELL(HAS_IN_CELL)) u_chk (
    .tck       (tck),
    .rst       (rst),
    .scan_in   (scan_in),
    .shift_sel (shift_sel),
    .dr_en     (dr_en),
    .update_en (update_en),
    .test_mode (test_mode),
    .core_out  (core_out),
    .core_oe   (core_oe),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .core_in   (core_in),
    .cap_q     (cap_q),
    .upd_q     (upd_q)
);

// File: tb/bsc_bidir_pad_tb.sv
`timescale 1ns/1ps
module bsc_bidir_pad_tb;

    logic tck = 1'b0;
    always #2.5 tck = ~tck;

    logic rst = 1'b1, scan_in = 1'b0, shift_sel = 1'b0, dr_en = 1'b0;
    logic update_en = 1'b0, test_mode = 1'b0;
    logic core_out_a = 1'b0, core_oe_a = 1'b0, pad_in_a = 1'b0;
    logic core_out_b = 1'b0, core_oe_b = 1'b0, pad_in_b = 1'b0;
    logic mid, scan_out, pad_out_a, pad_oe_a, core_in_a, pad_out_b, pad_oe_b, core_in_b;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // behavioural model: bit 0 = first cell after scan_in, bit 4 = last cell
    logic [4:0] mc = '0;
    logic [4:0] mu = '0;

    bsc_bidir_pad #(.HAS_IN_CELL(1'b1)) u_dut (
        .tck(tck), .rst(rst), .scan_in(scan_in), .shift_sel(shift_sel),
        .dr_en(dr_en), .update_en(update_en), .test_mode(test_mode),
        .core_out(core_out_a), .core_oe(core_oe_a), .pad_in(pad_in_a),
        .scan_out(mid), .pad_out(pad_out_a), .pad_oe(pad_oe_a), .core_in(core_in_a)
    );

    bsc_bidir_pad #(.HAS_IN_CELL(1'b0)) u_dut_b (
        .tck(tck), .rst(rst), .scan_in(mid), .shift_sel(shift_sel),
        .dr_en(dr_en), .update_en(update_en), .test_mode(test_mode),
        .core_out(core_out_b), .core_oe(core_oe_b), .pad_in(pad_in_b),
        .scan_out(scan_out), .pad_out(pad_out_b), .pad_oe(pad_oe_b), .core_in(core_in_b)
    );

    task automatic chk(input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %b expected %b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic model_rise();
        logic oe_a, oe_b;
        oe_a = test_mode ? mu[0] : core_oe_a;
        oe_b = test_mode ? mu[3] : core_oe_b;
        if (rst) mc = '0;
        else if (dr_en) begin
            if (shift_sel) mc = {mc[3:0], scan_in};
            else mc = {(oe_b ? core_out_b : pad_in_b), core_oe_b,
                       pad_in_a, (oe_a ? core_out_a : pad_in_a), core_oe_a};
        end
    endtask

    task automatic model_fall();
        if (rst) mu = '0;
        else if (update_en) mu = mc;
    endtask

    task automatic compare();
        chk("pad_oe_a",  pad_oe_a,  test_mode ? mu[0] : core_oe_a);
        chk("pad_out_a", pad_out_a, test_mode ? mu[1] : core_out_a);
        chk("core_in_a", core_in_a, test_mode ? mu[2] : pad_in_a);
        chk("pad_oe_b",  pad_oe_b,  test_mode ? mu[3] : core_oe_b);
        chk("pad_out_b", pad_out_b, test_mode ? mu[4] : core_out_b);
        chk("core_in_b", core_in_b, pad_in_b);
        chk("mid",       mid,       mc[2]);
        chk("scan_out",  scan_out,  mc[4]);
    endtask

    // one cycle: new inputs applied 1 ns after the rising edge, compared 1.5 ns after the falling edge
    task automatic cyc(input logic r, input logic en, input logic sh, input logic si,
                       input logic up, input logic tm);
        @(posedge tck);
        model_rise();
        #1;
        rst = r; dr_en = en; shift_sel = sh; scan_in = si; update_en = up; test_mode = tm;
        @(negedge tck);
        model_fall();
        #1.5;
        compare();
    endtask

    task automatic pads(input logic oa, input logic ea, input logic ia,
                        input logic ob, input logic eb, input logic ib);
        core_out_a = oa; core_oe_a = ea; pad_in_a = ia;
        core_out_b = ob; core_oe_b = eb; pad_in_b = ib;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL R1 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        logic tm_hold;
        // R1: reset clears every stage; pad undriven in test mode
        tag = "R1";
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1);
        chk("pad_oe_after_reset", pad_oe_a, 1'b0);
        chk("pad_out_after_reset", pad_out_a, 1'b0);

        // R8: normal mode passes core values through
        tag = "R8";
        pads(1, 1, 0, 0, 1, 1); cyc(0, 0, 0, 0, 0, 0);
        pads(0, 1, 1, 1, 0, 0); cyc(0, 0, 0, 0, 0, 0);
        pads(1, 0, 1, 1, 1, 1); cyc(0, 0, 0, 0, 0, 0);

        // R2: shift a pattern through both segments
        tag = "R2";
        for (int i = 0; i < 10; i++) cyc(0, 1, 1, (i % 3) == 0, 0, 0);

        // R6: update then hand the pad to the update stages
        tag = "R6";
        cyc(0, 0, 0, 0, 1, 0);
        tag = "R9";
        cyc(0, 0, 0, 0, 0, 1);
        pads(0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 1);
        tag = "R10";
        pads(1, 1, 1, 1, 1, 1); cyc(0, 0, 0, 0, 0, 1);
        pads(0, 1, 0, 1, 0, 0); cyc(0, 0, 0, 0, 0, 1);

        // R7: shifting in test mode leaves pad outputs unchanged
        tag = "R7";
        for (int i = 0; i < 6; i++) cyc(0, 1, 1, i[0], 0, 1);

        // R3 R4 R5: capture in normal mode, A driving, B receiving, then shift out
        tag = "R3";
        pads(1, 1, 0, 0, 0, 1);
        cyc(0, 1, 0, 0, 0, 0);
        tag = "R4";
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0, 0, 0);
        tag = "R5";
        pads(0, 0, 1, 1, 1, 0);
        cyc(0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 1, 0, 0);

        // R4: capture with direction set by update stages in test mode
        tag = "R4";
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, (i == 0) || (i == 3), 0, 1);
        cyc(0, 0, 0, 0, 1, 1);
        pads(1, 0, 0, 0, 1, 1);
        cyc(0, 1, 0, 0, 0, 1);
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0, 0, 1);

        // R11: disabled stages ignore shift and scan_in
        tag = "R11";
        cyc(0, 1, 1, 1, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, i[0], ~i[0], 0, 0);

        // mixed traffic
        tag = "R2";
        lfsr = 8'hA5;
        tm_hold = 1'b0;
        for (int i = 0; i < 120; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            pads(lfsr[0], lfsr[2], lfsr[4], lfsr[6], lfsr[1], lfsr[3]);
            if (lfsr[7:5] == 3'b000) tm_hold = ~tm_hold;
            cyc(0, lfsr[5] | lfsr[6], ~lfsr[7], lfsr[3], lfsr[1] & lfsr[2], tm_hold);
        end

        // R1: reset mid-run clears state again
        tag = "R1";
        cyc(1, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule